// File: doc/BRIEF.md
# Small CPU Memory Address Decoder

This block sits between the 16-bit address bus of an 8-bit processor and the on-chip memories of a small system. From the address alone it picks one of four targets: two 2K×8 read/write banks stacked upward from address zero, one 2K×8 program bank anchored at the top of the address space, or a two-byte peripheral window. It produces one write enable per writable device, a read strobe for the peripheral, and the multiplexed read byte that goes back to the processor.

The memories are synchronous and return data one cycle after the address. The decoder therefore registers the selected device together with the access and steers the read multiplexer with that registered select. Any read that no device claims returns the byte 0x00. The processor decodes 0x00 as its break opcode, so a stray fetch or a wild pointer ends in a software trap instead of running garbage.

Top module: `memmap_decode`

## Requirements
- R1: An address in 0x0000–0x07FF asserts ram0Sel only. A valid write there asserts ram0We. A valid read returns ram0RdData on cpuRdData in the following cycle.
- R2: An address in 0x0800–0x0FFF asserts ram1Sel only. A valid write there asserts ram1We. A valid read returns ram1RdData in the following cycle, and data written to one RAM bank never appears in the other.
- R3: An address whose bits 15:11 are all ones (0xF800–0xFFFF, which includes the vector words at 0xFFFA–0xFFFF) asserts romSel. A valid read returns romRdData in the following cycle.
- R4: A write to the ROM region or to an unmapped address asserts none of ram0We, ram1We or perWe. A write with cpuValid low asserts none of them either, and the RAM contents are unchanged when read back afterwards.
- R5: A valid read of an address no device claims (for example 0x1002, 0x2000, 0xF7FF) returns 0x00 on cpuRdData in the following cycle.
- R6: Addresses 0x1000 and 0x1001 assert perSel. perAddr carries address bit 0 (0 for the data byte, 1 for status). A valid write there asserts perWe, and a valid read returns perRdData in the following cycle.
- R7: At most one of the four selects is high, exactly one for a mapped address and none for an unmapped one. The selects follow the address combinationally, whatever the value of cpuValid.
- R8: cpuRdData in a cycle comes from the device selected by the valid read in the previous cycle, even when the address has since changed. After a cycle with no valid read, cpuRdData is 0x00.
- R9: perRd is high only in a cycle with a valid read of the peripheral window whose previous cycle was not also one. A read held for several cycles therefore gives a single one-cycle pulse.
- R10: During and just after reset, cpuRdData is 0x00, and with cpuValid low no write enable or read strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | Processor address |
| cpuWrData | input | 8 | Processor write data |
| cpuWe | input | 1 | 1 = write cycle, 0 = read cycle |
| cpuValid | input | 1 | Bus cycle valid |
| ram0RdData | input | 8 | Read data from RAM bank 0 (one-cycle latency) |
| ram1RdData | input | 8 | Read data from RAM bank 1 (one-cycle latency) |
| romRdData | input | 8 | Read data from the ROM bank (one-cycle latency) |
| perRdData | input | 8 | Read data from the peripheral (one-cycle latency) |
| memAddr | output | 11 | Offset within a 2K bank |
| memWrData | output | 8 | Write data to the devices |
| ram0Sel | output | 1 | RAM bank 0 selected |
| ram1Sel | output | 1 | RAM bank 1 selected |
| romSel | output | 1 | ROM bank selected |
| perSel | output | 1 | Peripheral window selected |
| ram0We | output | 1 | RAM bank 0 write enable |
| ram1We | output | 1 | RAM bank 1 write enable |
| perWe | output | 1 | Peripheral write enable |
| perRd | output | 1 | Peripheral read strobe, one-cycle pulse |
| perAddr | output | 1 | Register index inside the peripheral window |
| cpuRdData | output | 8 | Multiplexed read data to the processor |

## Verification
A corrupted registered read select shows up one cycle after the read that set it: a byte from the wrong bank, or 0x00 where data was expected, or a device byte where 0x00 was expected. The bench catches this by issuing back-to-back reads to different devices. A faulty decode or write-enable path shows in the same cycle as a wrong select or enable, and later as a RAM readback that carries another bank's data or a value that should not have been written. A broken peripheral edge detector shows within the first two cycles of a held read, as a missing pulse or a repeated one.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int DEV_CNT = 4;
  localparam int IDX_RAM0 = 0;
  localparam int IDX_RAM1 = 1;
  localparam int IDX_ROM  = 2;
  localparam int IDX_PER  = 3;

  typedef struct packed {
    logic [DEV_CNT-1:0] selNow;  // combinational one-hot select
    logic [DEV_CNT-1:0] selRdQ;  // select registered with a valid read
    logic               wrStb;   // valid write cycle
    logic               rdStb;   // valid read cycle
  } ctrlBusT;
endpackage

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_AW = 11,
  parameter int PER_AW = 1,
  parameter logic [ADDR_W-1:0] PER_BASE = 16'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic              cpuValid,
  output ctrlBusT           ctrlBus,
  output logic              perRd
);
  localparam int BANK_IW = ADDR_W - BANK_AW;

  logic [BANK_IW-1:0] bankIdx;
  logic [DEV_CNT-1:0] selNow;
  logic [DEV_CNT-1:0] selRdQ;
  logic               rdStb;
  logic               perRdNow;
  logic               perRdPrevQ;
  logic               pastOk;

  assign bankIdx = cpuAddr[ADDR_W-1:BANK_AW];

  always_comb begin
    selNow = '0;
    selNow[IDX_RAM0] = (bankIdx == BANK_IW'(0));
    selNow[IDX_RAM1] = (bankIdx == BANK_IW'(1));
    selNow[IDX_ROM]  = (&bankIdx);
    selNow[IDX_PER]  = (cpuAddr[ADDR_W-1:PER_AW] == PER_BASE[ADDR_W-1:PER_AW]);
  end

  assign rdStb    = cpuValid && !cpuWe;
  assign perRdNow = rdStb && selNow[IDX_PER];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selRdQ     <= '0;
      perRdPrevQ <= 1'b0;
      pastOk     <= 1'b0;
    end else begin
      selRdQ     <= rdStb ? selNow : '0;
      perRdPrevQ <= perRdNow;
      pastOk     <= 1'b1;
    end
  end

  assign perRd = perRdNow && !perRdPrevQ;

  assign ctrlBus.selNow = selNow;
  assign ctrlBus.selRdQ = selRdQ;
  assign ctrlBus.wrStb  = cpuValid && cpuWe;
  assign ctrlBus.rdStb  = rdStb;

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selNow) && $onehot0(selRdQ));

  // R9
  per_rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    perRd |=> !perRd);

  // R5
  unmapped_rd_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && selNow == '0) |=> (selRdQ == '0));

  // R8
  rd_sel_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(rdStb)) |-> (selRdQ == '0));
endmodule

// File: rtl/memmap_dpath.sv
module memmap_dpath
  import memmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = 8'h00,
  parameter logic [DEV_CNT-1:0] WR_MASK = 4'b1011
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlBusT                       ctrlBus,
  input  logic [DEV_CNT-1:0][DATA_W-1:0] devRdData,
  output logic [DEV_CNT-1:0]            devWe,
  output logic [DATA_W-1:0]             rdData
);
  logic [DEV_CNT-1:0][DATA_W-1:0] gated;
  logic [DATA_W-1:0] orMux;
  logic pastOk;

  for (genvar i = 0; i < DEV_CNT; i++) begin : g_dev
    if (WR_MASK[i]) begin : g_wr
      assign devWe[i] = ctrlBus.selNow[i] && ctrlBus.wrStb;
    end else begin : g_ro
      assign devWe[i] = 1'b0;
    end
    assign gated[i] = ctrlBus.selRdQ[i] ? devRdData[i] : '0;
  end

  always_comb begin
    orMux = '0;
    for (int i = 0; i < DEV_CNT; i++) orMux = orMux | gated[i];
  end

  assign rdData = (|ctrlBus.selRdQ) ? orMux : FILL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R3
  rom_rd_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(ctrlBus.rdStb && ctrlBus.selNow[IDX_ROM]))
      |-> (rdData == devRdData[IDX_ROM]));

  // R4
  ro_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.selNow[IDX_ROM] || ctrlBus.selNow == '0 || !ctrlBus.wrStb) |-> (devWe == '0));

  // R5
  unmapped_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(ctrlBus.rdStb && ctrlBus.selNow == '0)) |-> (rdData == FILL));
endmodule

// File: rtl/memmap_decode.sv
module memmap_decode
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_AW = 11,
  parameter int PER_AW = 1,
  parameter logic [ADDR_W-1:0] PER_BASE = 16'h1000,
  parameter logic [DATA_W-1:0] FILL = 8'h00
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]  cpuWrData,
  input  logic               cpuWe,
  input  logic               cpuValid,
  input  logic [DATA_W-1:0]  ram0RdData,
  input  logic [DATA_W-1:0]  ram1RdData,
  input  logic [DATA_W-1:0]  romRdData,
  input  logic [DATA_W-1:0]  perRdData,
  output logic [BANK_AW-1:0] memAddr,
  output logic [DATA_W-1:0]  memWrData,
  output logic               ram0Sel,
  output logic               ram1Sel,
  output logic               romSel,
  output logic               perSel,
  output logic               ram0We,
  output logic               ram1We,
  output logic               perWe,
  output logic               perRd,
  output logic [PER_AW-1:0]  perAddr,
  output logic [DATA_W-1:0]  cpuRdData
);
  ctrlBusT ctrlBus;
  logic [DEV_CNT-1:0][DATA_W-1:0] devRdData;
  logic [DEV_CNT-1:0] devWe;

  memmap_ctrl #(
    .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .PER_AW(PER_AW), .PER_BASE(PER_BASE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuValid(cpuValid), .ctrlBus(ctrlBus), .perRd(perRd)
  );

  assign devRdData[IDX_RAM0] = ram0RdData;
  assign devRdData[IDX_RAM1] = ram1RdData;
  assign devRdData[IDX_ROM]  = romRdData;
  assign devRdData[IDX_PER]  = perRdData;

  memmap_dpath #(.DATA_W(DATA_W), .FILL(FILL)) dpath_i (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus), .devRdData(devRdData),
    .devWe(devWe), .rdData(cpuRdData)
  );

  assign memAddr   = cpuAddr[BANK_AW-1:0];
  assign perAddr   = cpuAddr[PER_AW-1:0];
  assign memWrData = cpuWrData;
  assign ram0Sel   = ctrlBus.selNow[IDX_RAM0];
  assign ram1Sel   = ctrlBus.selNow[IDX_RAM1];
  assign romSel    = ctrlBus.selNow[IDX_ROM];
  assign perSel    = ctrlBus.selNow[IDX_PER];
  assign ram0We    = devWe[IDX_RAM0];
  assign ram1We    = devWe[IDX_RAM1];
  assign perWe     = devWe[IDX_PER];
endmodule

// File: tb/memmap_decode_tb_top.sv
module memmap_decode_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic cpuWe = 1'b0, cpuValid = 1'b0;
  logic [7:0] ram0RdData, ram1RdData, romRdData, perRdData;
  logic [10:0] memAddr;
  logic [7:0] memWrData, cpuRdData;
  logic ram0Sel, ram1Sel, romSel, perSel, ram0We, ram1We, perWe, perRd;
  logic [0:0] perAddr;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic [7:0] ram0Mem [2048];
  logic [7:0] ram1Mem [2048];

  always #10 clk = ~clk;

  memmap_decode dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWe(cpuWe), .cpuValid(cpuValid), .ram0RdData(ram0RdData),
    .ram1RdData(ram1RdData), .romRdData(romRdData), .perRdData(perRdData),
    .memAddr(memAddr), .memWrData(memWrData), .ram0Sel(ram0Sel),
    .ram1Sel(ram1Sel), .romSel(romSel), .perSel(perSel), .ram0We(ram0We),
    .ram1We(ram1We), .perWe(perWe), .perRd(perRd), .perAddr(perAddr),
    .cpuRdData(cpuRdData)
  );

  function automatic logic [7:0] romByte(input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'b10110};
  endfunction

  // behavioural synchronous memories, one-cycle read latency
  always_ff @(posedge clk) begin
    if (ram0We) ram0Mem[memAddr] <= memWrData;
    if (ram1We) ram1Mem[memAddr] <= memWrData;
    ram0RdData <= ram0Mem[memAddr];
    ram1RdData <= ram1Mem[memAddr];
    romRdData  <= romByte(memAddr);
    perRdData  <= perAddr[0] ? 8'h03 : 8'hC4;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // driver: one bus cycle, pushes the read byte expected in the next cycle
  task automatic go(input logic [15:0] a, input logic w, input logic [7:0] d,
                    input logic v, input logic [7:0] e, input string tag);
    @(negedge clk);
    cpuAddr = a; cpuWe = w; cpuWrData = d; cpuValid = v;
    expQ.push_back(e);
    tagQ.push_back(tag);
    #1;
  endtask

  task automatic checkSel(input logic [3:0] exp, input string tag);
    check({perSel, romSel, ram1Sel, ram0Sel} == exp, tag,
          {perSel, romSel, ram1Sel, ram0Sel}, exp);
  endtask

  task automatic checkWe(input logic [2:0] exp, input string tag);
    check({perWe, ram1We, ram0We} == exp, tag, {perWe, ram1We, ram0We}, exp);
  endtask

  // monitor: compares the read byte after each clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(cpuRdData === e, t, cpuRdData, e);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin
      ram0Mem[i] = 8'hE0;
      ram1Mem[i] = 8'hE1;
    end
    repeat (3) @(posedge clk);
    #2;
    check(cpuRdData == 8'h00, "R10 reset read", cpuRdData, 0);
    check({ram0We, ram1We, perWe, perRd} == 0, "R10 reset strobes",
          {ram0We, ram1We, perWe, perRd}, 0);
    @(negedge clk);
    rstN = 1'b1;
    #3;
    check(cpuRdData == 8'h00, "R10 after reset", cpuRdData, 0);

    // R1 / R2 writes and selects
    go(16'h0005, 1, 8'h11, 1, 8'h00, "R1 wr cycle");
    checkSel(4'b0001, "R1 sel");
    checkWe(3'b001, "R1 we");
    go(16'h0805, 1, 8'h22, 1, 8'h00, "R2 wr cycle");
    checkSel(4'b0010, "R2 sel");
    checkWe(3'b010, "R2 we");
    go(16'h07FF, 1, 8'h33, 1, 8'h00, "R1 wr top");
    checkSel(4'b0001, "R1 sel top");
    go(16'h0FFF, 1, 8'h44, 1, 8'h00, "R2 wr top");
    checkSel(4'b0010, "R2 sel top");
    // R4 ignored writes
    go(16'hF805, 1, 8'h99, 1, 8'h00, "R4 rom wr cycle");
    checkWe(3'b000, "R4 rom write");
    go(16'h2005, 1, 8'h99, 1, 8'h00, "R4 unmapped wr cycle");
    checkWe(3'b000, "R4 unmapped write");
    go(16'h0005, 1, 8'h99, 0, 8'h00, "R4 invalid wr cycle");
    checkWe(3'b000, "R4 invalid write");
    checkSel(4'b0001, "R7 sel without valid");

    // read back, back-to-back across devices (R8)
    go(16'h0005, 0, 8'h00, 1, 8'h11, "R1 rd");
    go(16'h0805, 0, 8'h00, 1, 8'h22, "R2 rd");
    go(16'h07FF, 0, 8'h00, 1, 8'h33, "R1 rd top");
    go(16'h0FFF, 0, 8'h00, 1, 8'h44, "R2 rd top");
    go(16'hFFFC, 0, 8'h00, 1, romByte(11'h7FC), "R3 reset vector lo");
    checkSel(4'b0100, "R3 sel");
    go(16'hFFFD, 0, 8'h00, 1, romByte(11'h7FD), "R3 reset vector hi");
    go(16'hF800, 0, 8'h00, 1, romByte(11'h000), "R3 rom base");
    go(16'hF805, 0, 8'h00, 1, romByte(11'h005), "R3 rom after write");
    go(16'h0000, 0, 8'h00, 1, 8'hE0, "R4 ram0 unwritten");
    go(16'h0005, 0, 8'h00, 1, 8'h11, "R4 invalid write kept");
    go(16'h0005, 0, 8'h00, 0, 8'h00, "R8 no valid read");

    // R5 unmapped
    go(16'h1002, 0, 8'h00, 1, 8'h00, "R5 unmapped 1002");
    checkSel(4'b0000, "R7 no sel 1002");
    go(16'hF7FF, 0, 8'h00, 1, 8'h00, "R5 unmapped F7FF");
    checkSel(4'b0000, "R7 no sel F7FF");
    go(16'h2000, 0, 8'h00, 1, 8'h00, "R5 unmapped 2000");

    // R6 / R9 peripheral
    go(16'h1001, 0, 8'h00, 1, 8'h03, "R6 status rd");
    checkSel(4'b1000, "R6 sel");
    check(perAddr == 1'b1, "R6 perAddr status", perAddr, 1);
    check(perRd == 1'b1, "R9 first pulse", perRd, 1);
    go(16'h1001, 0, 8'h00, 1, 8'h03, "R6 status held");
    check(perRd == 1'b0, "R9 held no pulse", perRd, 0);
    go(16'h1000, 0, 8'h00, 1, 8'hC4, "R6 data held");
    check(perRd == 1'b0, "R9 held again", perRd, 0);
    go(16'h1000, 0, 8'h00, 0, 8'h00, "R9 gap");
    check(perRd == 1'b0, "R9 no valid", perRd, 0);
    go(16'h1000, 0, 8'h00, 1, 8'hC4, "R6 data rd");
    check(perRd == 1'b1, "R9 new pulse", perRd, 1);
    check(perAddr == 1'b0, "R6 perAddr data", perAddr, 0);
    go(16'h1000, 1, 8'h5A, 1, 8'h00, "R6 wr cycle");
    checkWe(3'b100, "R6 per write");
    check(perRd == 1'b0, "R9 no pulse on write", perRd, 0);
    go(16'h0000, 0, 8'h00, 0, 8'h00, "R8 idle");
    go(16'h0000, 0, 8'h00, 0, 8'h00, "R8 idle2");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule